// File: doc/BRIEF.md
# Ethernet Receive CRC Checker

This block watches the nibble-wide receive side of a 100 Mbit/s media-independent interface, where data arrives four bits at a time on a 25 MHz receive clock. It discards the run of alternating preamble nibbles and the start-of-frame delimiter. It then pairs the following nibbles into bytes, low nibble first, and folds every byte of the frame into a CRC-32. The trailing four check bytes are folded in as well.

When the data-valid line drops, the block gives a one-cycle completion strobe. Together with the strobe it gives a pass/fail verdict, which it reaches by comparing the final CRC register against the fixed residual that every intact frame leaves. It also gives a debug word holding the check value computed over the frame body, so that word can be set beside the check bytes actually received. A frame that ends on half a byte fails. A frame during which the receive-error line was raised also fails.

Top module: `eth_rx_crc_check`

## Requirements
- R1: After reset, and until the first frame completes, `frame_done`, `fcs_ok` and `fcs_calc` are all zero.
- R2: While `rx_dv` is high, nibbles are skipped until the nibble 0xD (the high half of the delimiter byte 0xD5) is seen; the CRC starts with the byte that follows. If `rx_dv` drops before a 0xD nibble is seen, no strobe is given. The preamble length does not affect the result.
- R3: Within each byte, the nibble received first supplies bits 3:0 and the second supplies bits 7:4.
- R4: The CRC register is preset to all ones at each delimiter and shifts each byte in LSB first with the reflected polynomial 0xEDB88320. A frame whose last four bytes are the complement of the CRC over the preceding bytes, sent low byte first, gives `fcs_ok` = 1.
- R5: A frame with any corrupted byte gives `fcs_ok` = 0. This includes an all-zero body followed by an all-zero check field.
- R6: `fcs_calc` is the complement of the CRC over all bytes except the last four, with bits 7:0 being the value expected in the first check byte. It is 0x00000000 when the frame holds four or fewer bytes.
- R7: A frame that ends with an odd number of data nibbles gives `fcs_ok` = 0, even when its whole bytes would pass.
- R8: If `rx_er` is high in any cycle where `rx_dv` is high after the delimiter, the frame gives `fcs_ok` = 0.
- R9: `frame_done` is high for exactly one cycle. That cycle follows the second rising edge that samples `rx_dv` low after the frame's data, which is one clock after the last byte is folded.
- R10: `fcs_ok` and `fcs_calc` change only together with `frame_done` and hold their values between strobes.
- R11: Frames separated by a single idle cycle are each checked on their own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_dv | input | 1 | Receive data valid |
| rxd | input | 4 | Receive data nibble |
| rx_er | input | 1 | Receive error indication |
| frame_done | output | 1 | One-cycle frame completion strobe |
| fcs_ok | output | 1 | Verdict for the last completed frame |
| fcs_calc | output | 32 | Check value computed over the frame body |

## Verification
The bench uses intact frames of several lengths and preamble lengths, where only a pass with the right check value is acceptable. These frames show that the delimiter search and the CRC preset are correct. Frames that are corrupted, frames with swapped nibbles, and frames with an all-zero body and check field each tell a real residual comparison apart from a check that passes trivially; the swapped-nibble frames also show that nibble order matters. Frames with an odd tail, frames with a receive error, preamble-only bursts, empty frames, frames of exactly four bytes, and back-to-back frames separate the rules for the verdict, the strobe and the debug value from those for the CRC itself.

// File: rtl/eth_rx_crc_pkg.sv
package eth_rx_crc_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int CRC_W  = 32;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HUNT = 2'd1,
        RX_DATA = 2'd2
    } rx_phase_e;

    // Fold one byte into a reflected CRC register, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data_in,
        input logic [CRC_W-1:0]  poly
    );
        logic [CRC_W-1:0] c;
        c = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, data_in};
        for (int k = 0; k < BYTE_W; k++) begin
            if (c[0]) c = (c >> 1) ^ poly;
            else      c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [CRC_W-1:0] bit_mirror(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int k = 0; k < CRC_W; k++) r[k] = v[CRC_W-1-k];
        return r;
    endfunction

endpackage

// File: rtl/rx_nibble_framer.sv
module rx_nibble_framer
    import eth_rx_crc_pkg::*;
#(
    parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_dv,
    input  logic [NIB_W-1:0]  rxd,
    input  logic              rx_er,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld,
    output logic              sof,
    output logic              eof,
    output logic              eof_odd,
    output logic              eof_err
);

    typedef struct packed {
        rx_phase_e         st;
        logic              half;
        logic [NIB_W-1:0]  low;
        logic [BYTE_W-1:0] data_b;
        logic              bv;
        logic              sof;
        logic              eof;
        logic              odd;
        logic              err;
        logic              err_acc;
    } framer_t;

    framer_t fr_d, fr_q;

    always_comb begin
        fr_d     = fr_q;
        fr_d.bv  = 1'b0;
        fr_d.sof = 1'b0;
        fr_d.eof = 1'b0;
        unique case (fr_q.st)
            RX_IDLE, RX_HUNT: begin
                if (!rx_dv) begin
                    fr_d.st = RX_IDLE;
                end else if (rxd == SFD_NIB) begin
                    fr_d.st      = RX_DATA;
                    fr_d.sof     = 1'b1;
                    fr_d.half    = 1'b0;
                    fr_d.err_acc = 1'b0;
                end else begin
                    fr_d.st = RX_HUNT;
                end
            end
            RX_DATA: begin
                if (!rx_dv) begin
                    fr_d.st  = RX_IDLE;
                    fr_d.eof = 1'b1;
                    fr_d.odd = fr_q.half;
                    fr_d.err = fr_q.err_acc;
                end else begin
                    if (rx_er) fr_d.err_acc = 1'b1;
                    if (!fr_q.half) begin
                        fr_d.low  = rxd;
                        fr_d.half = 1'b1;
                    end else begin
                        fr_d.data_b = {rxd, fr_q.low};
                        fr_d.bv     = 1'b1;
                        fr_d.half   = 1'b0;
                    end
                end
            end
            default: fr_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{st: RX_IDLE, default: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign byte_data = fr_q.data_b;
    assign byte_vld  = fr_q.bv;
    assign sof       = fr_q.sof;
    assign eof       = fr_q.eof;
    assign eof_odd   = fr_q.odd;
    assign eof_err   = fr_q.err;

endmodule

// File: rtl/rx_crc_engine.sv
module rx_crc_engine
    import eth_rx_crc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY      = 32'hEDB88320,
    parameter int               FCS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [CRC_W-1:0]  crc_state,
    output logic [CRC_W-1:0]  crc_body
);

    localparam int HIST_LAST = FCS_BYTES - 1;

    typedef struct packed {
        logic [CRC_W-1:0]                crc;
        logic [FCS_BYTES-1:0][CRC_W-1:0] hist;
    } engine_t;

    engine_t en_d, en_q;
    logic [FCS_BYTES-1:0][CRC_W-1:0] hist_shift;

    // History of register values one byte apart; the oldest entry is the
    // state reached before the final check bytes entered.
    for (genvar i = 0; i < FCS_BYTES; i++) begin : g_hist
        if (i == 0) begin : g_head
            assign hist_shift[i] = en_q.crc;
        end else begin : g_tail
            assign hist_shift[i] = en_q.hist[i-1];
        end
    end

    always_comb begin
        en_d = en_q;
        if (sof) begin
            en_d.crc  = '1;
            en_d.hist = '1;
        end else if (byte_vld) begin
            en_d.hist = hist_shift;
            en_d.crc  = crc_fold_byte(en_q.crc, byte_data, POLY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '1;
        end else begin
            en_q <= en_d;
        end
    end

    assign crc_state = en_q.crc;
    assign crc_body  = en_q.hist[HIST_LAST];

endmodule

// File: rtl/rx_fcs_verdict.sv
module rx_fcs_verdict
    import eth_rx_crc_pkg::*;
#(
    parameter logic [CRC_W-1:0] RESIDUE = 32'hC704DD7B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof,
    input  logic             eof_odd,
    input  logic             eof_err,
    input  logic [CRC_W-1:0] crc_state,
    input  logic [CRC_W-1:0] crc_body,
    output logic             frame_done,
    output logic             fcs_ok,
    output logic [CRC_W-1:0] fcs_calc
);

    // The residual is quoted in MSB-first form; the register is reflected.
    localparam logic [CRC_W-1:0] RESIDUE_REG = bit_mirror(RESIDUE);

    typedef struct packed {
        logic             done;
        logic             ok;
        logic [CRC_W-1:0] fcs;
    } verdict_t;

    verdict_t vd_d, vd_q;

    always_comb begin
        vd_d      = vd_q;
        vd_d.done = 1'b0;
        if (eof) begin
            vd_d.done = 1'b1;
            vd_d.ok   = (crc_state == RESIDUE_REG) && !eof_odd && !eof_err;
            vd_d.fcs  = ~crc_body;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign frame_done = vd_q.done;
    assign fcs_ok     = vd_q.ok;
    assign fcs_calc   = vd_q.fcs;

endmodule

// File: rtl/eth_rx_crc_check.sv
module eth_rx_crc_check
    import eth_rx_crc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY      = 32'hEDB88320,
    parameter logic [CRC_W-1:0] RESIDUE   = 32'hC704DD7B,
    parameter int               FCS_BYTES = 4,
    parameter logic [NIB_W-1:0] SFD_NIB   = 4'hD
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_dv,
    input  logic [3:0]  rxd,
    input  logic        rx_er,
    output logic        frame_done,
    output logic        fcs_ok,
    output logic [31:0] fcs_calc
);

    logic [BYTE_W-1:0] byte_w;
    logic              byte_vld_w;
    logic              sof_w;
    logic              eof_w;
    logic              eof_odd_w;
    logic              eof_err_w;
    logic [CRC_W-1:0]  crc_state_w;
    logic [CRC_W-1:0]  crc_body_w;

    rx_nibble_framer #(.SFD_NIB(SFD_NIB)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_dv    (rx_dv),
        .rxd      (rxd),
        .rx_er    (rx_er),
        .byte_data(byte_w),
        .byte_vld (byte_vld_w),
        .sof      (sof_w),
        .eof      (eof_w),
        .eof_odd  (eof_odd_w),
        .eof_err  (eof_err_w)
    );

    rx_crc_engine #(.POLY(POLY), .FCS_BYTES(FCS_BYTES)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (sof_w),
        .byte_vld (byte_vld_w),
        .byte_data(byte_w),
        .crc_state(crc_state_w),
        .crc_body (crc_body_w)
    );

    rx_fcs_verdict #(.RESIDUE(RESIDUE)) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .eof       (eof_w),
        .eof_odd   (eof_odd_w),
        .eof_err   (eof_err_w),
        .crc_state (crc_state_w),
        .crc_body  (crc_body_w),
        .frame_done(frame_done),
        .fcs_ok    (fcs_ok),
        .fcs_calc  (fcs_calc)
    );

endmodule

// File: rtl/eth_rx_crc_check_sva.sv
module eth_rx_crc_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_dv,
    input logic        sof,
    input logic        eof,
    input logic        eof_odd,
    input logic        eof_err,
    input logic [31:0] crc_state,
    input logic        frame_done,
    input logic        fcs_ok,
    input logic [31:0] fcs_calc
);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r9_done_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !$past(rx_dv, 2));

    a_r7_odd_tail_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && eof_odd) |=> (frame_done && !fcs_ok));

    a_r8_rx_error_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && eof_err) |=> (frame_done && !fcs_ok));

    a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> ($stable(fcs_ok) && $stable(fcs_calc)));

    a_r4_preset_ones: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (crc_state == 32'hFFFF_FFFF));

endmodule

bind eth_rx_crc_check eth_rx_crc_check_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_dv     (rx_dv),
    .sof       (sof_w),
    .eof       (eof_w),
    .eof_odd   (eof_odd_w),
    .eof_err   (eof_err_w),
    .crc_state (crc_state_w),
    .frame_done(frame_done),
    .fcs_ok    (fcs_ok),
    .fcs_calc  (fcs_calc)
);

// File: tb/eth_rx_crc_check_bench.sv
module eth_rx_crc_check_bench;

    typedef logic [7:0] bq_t[$];
    typedef struct {
        logic        ok;
        logic [31:0] fcs;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_dv = 1'b0;
    logic [3:0]  rxd = 4'h0;
    logic        rx_er = 1'b0;
    logic        frame_done;
    logic        fcs_ok;
    logic [31:0] fcs_calc;

    int checks = 0;
    int errors = 0;
    int dones_seen = 0;
    int dones_exp = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    eth_rx_crc_check u_eth_rx_crc_check (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rxd(rxd), .rx_er(rx_er),
        .frame_done(frame_done), .fcs_ok(fcs_ok), .fcs_calc(fcs_calc)
    );

    task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                       input logic [31:0] exp_v);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Independent bitwise CRC-32 model: preset ones, LSB first, complemented.
    function automatic logic [31:0] ref_crc(input bq_t b, input int n);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                if (r[0] ^ b[i][k]) r = (r >> 1) ^ 32'hEDB88320;
                else                r = r >> 1;
            end
        end
        return ~r;
    endfunction

    function automatic bq_t with_fcs(input bq_t p);
        bq_t f = p;
        logic [31:0] c = ref_crc(p, p.size());
        for (int k = 0; k < 4; k++) f.push_back(c[8*k +: 8]);
        return f;
    endfunction

    task automatic nib(input logic [3:0] v, input logic er);
        @(negedge clk);
        rx_dv = 1'b1;
        rxd   = v;
        rx_er = er;
    endtask

    task automatic send_frame(input bq_t b, input int pre, input bit odd,
                              input int er_at, input int gap, input string tag);
        int n = b.size();
        exp_t e;
        logic [31:0] body = (n >= 4) ? ref_crc(b, n - 4) : 32'h0;
        e.fcs = body;
        e.ok  = (n >= 4) && ({b[n-1], b[n-2], b[n-3], b[n-4]} == body)
                && !odd && (er_at < 0);
        e.tag = tag;
        sb.push_back(e);
        dones_exp++;
        for (int i = 0; i < pre; i++) nib(4'h5, 1'b0);
        nib(4'hD, 1'b0);
        for (int i = 0; i < n; i++) begin
            nib(b[i][3:0], (er_at == 2*i));
            nib(b[i][7:4], (er_at == 2*i + 1));
        end
        if (odd) nib(4'hA, 1'b0);
        @(negedge clk);
        rx_dv = 1'b0; rxd = 4'h0; rx_er = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // Monitor: samples one time unit after each rising edge.
    initial begin
        bit   prev_dv = 1'b0;
        int   since = 0;
        bit   hold_bad = 1'b0;
        bit   want_low = 1'b0;
        logic last_ok = 1'b0;
        logic [31:0] last_fcs = 32'h0;
        exp_t e;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (prev_dv && !rx_dv) since = 1;
            else if (since > 0) since++;
            prev_dv = rx_dv;
            if (want_low) begin
                chk(!frame_done, "R9 strobe width", {31'h0, frame_done}, 32'h0);
                want_low = 1'b0;
            end
            if (frame_done) begin
                dones_seen++;
                want_low = 1'b1;
                if (sb.size() == 0) begin
                    chk(1'b0, "R2 unexpected strobe", 32'h1, 32'h0);
                end else begin
                    e = sb.pop_front();
                    chk(fcs_ok == e.ok, {e.tag, " verdict"}, {31'h0, fcs_ok}, {31'h0, e.ok});
                    chk(fcs_calc == e.fcs, {"R6 ", e.tag, " fcs_calc"}, fcs_calc, e.fcs);
                    chk(since == 2, {"R9 ", e.tag, " strobe timing"}, since, 32'd2);
                    chk(!hold_bad, {"R10 ", e.tag, " hold between strobes"}, {31'h0, hold_bad}, 32'h0);
                end
                hold_bad = 1'b0;
                last_ok  = fcs_ok;
                last_fcs = fcs_calc;
            end else if (fcs_ok !== last_ok || fcs_calc !== last_fcs) begin
                hold_bad = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bq_t p, g, s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(frame_done == 1'b0, "R1 reset frame_done", {31'h0, frame_done}, 32'h0);
        chk(fcs_ok == 1'b0, "R1 reset fcs_ok", {31'h0, fcs_ok}, 32'h0);
        chk(fcs_calc == 32'h0, "R1 reset fcs_calc", fcs_calc, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4/R2: intact frame with a long preamble
        p = {}; for (int i = 0; i < 10; i++) p.push_back(8'h11 * i + 8'h3C);
        g = with_fcs(p);
        send_frame(g, 15, 1'b0, -1, 4, "R4 long preamble good");
        // R2: same frame, short preamble
        send_frame(g, 3, 1'b0, -1, 4, "R2 short preamble good");
        // R3: swapped nibble order must fail
        s = {}; foreach (g[i]) s.push_back({g[i][3:0], g[i][7:4]});
        send_frame(s, 7, 1'b0, -1, 4, "R3 swapped nibbles");
        // R5: all-zero body with zero check field
        s = {}; for (int i = 0; i < 12; i++) s.push_back(8'h00);
        send_frame(s, 7, 1'b0, -1, 4, "R5 all-zero frame");
        // R5: single corrupted byte
        s = g; s[4] = s[4] ^ 8'h08;
        send_frame(s, 7, 1'b0, -1, 4, "R5 corrupted byte");
        // R7: odd nibble tail
        send_frame(g, 7, 1'b1, -1, 4, "R7 odd tail");
        // R8: receive error mid-frame
        send_frame(g, 7, 1'b0, 9, 4, "R8 rx_er in frame");
        // R2: preamble only, no delimiter, no strobe
        for (int i = 0; i < 9; i++) nib(4'h5, 1'b0);
        @(negedge clk); rx_dv = 1'b0;
        repeat (5) @(negedge clk);
        // R6: empty frame and four-byte frame
        s = {};
        send_frame(s, 7, 1'b0, -1, 4, "R6 empty frame");
        s = {8'hDE, 8'hAD, 8'hBE, 8'hEF};
        send_frame(s, 7, 1'b0, -1, 4, "R6 four bytes");
        // R11: back-to-back frames, single idle cycle
        p = {}; for (int i = 0; i < 6; i++) p.push_back(8'hA0 + i);
        send_frame(with_fcs(p), 7, 1'b0, -1, 1, "R11 first of pair");
        p = {}; for (int i = 0; i < 9; i++) p.push_back(8'hF0 - 3*i);
        send_frame(with_fcs(p), 7, 1'b0, -1, 1, "R11 second of pair");
        // R4: long intact frame
        p = {}; for (int i = 0; i < 60; i++) p.push_back(i[7:0] * 8'd7);
        send_frame(with_fcs(p), 7, 1'b0, -1, 4, "R4 long frame good");

        repeat (10) @(negedge clk);
        chk(dones_seen == dones_exp, "R2 strobe count", dones_seen, dones_exp);
        chk(sb.size() == 0, "R9 pending expectations", sb.size(), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule